// File: doc/BRIEF.md
# Self-Timed Chip Erase Sequencer

This block erases a small register-based storage array on its own once the command decoder hands it a single-cycle start pulse. That pulse marks the rising edge of the last write strobe of the six-write erase command. The block runs in phases. It first writes 0x00 into every location and reads each one back. It then repeats timed erase pulses, each followed by a verify scan, until every cell reads 0xFF. If the number of pulses reaches a parameterised limit while the array is still not erased, it stops and reports failure. Erase physics is modelled as a fixed number of cycles per pulse. An erase takes hold once a set number of pulses has been applied, and a test input can hold the cells back so that the timeout path can be exercised.

The host reads through a valid/ready request channel carrying an address and gets the answer on a valid/ready response channel. While the sequencer is working, or after it has failed, a read returns a status byte instead of array data. Bit 7 is the data-poll bit, bit 6 is the toggle bit and bit 5 is the timeout flag. A plain write port loads the array while the block is idle. The `busy` output is a plain level.

Back-pressure rules: a request is accepted on a cycle with `rq_valid` and `rq_ready` both high. `rq_ready` is high only when the response register is empty or is being drained on that same cycle. A response appears one cycle after its request is accepted and stays unchanged until `rs_ready` takes it.

Top module: `erase_engine`

## Requirements
- R1: A start pulse while idle raises `busy` on the next cycle. A start pulse while busy or while in the failed state has no effect.
- R2: Before any erase pulse, every location is written with 0x00 and read back as 0x00. After a timed-out erase and a reset command, every location therefore reads 0x00.
- R3: When every location verifies as 0xFF after an erase pulse, `busy` falls and the block returns to array reads, where every location reads 0xFF.
- R4: A read accepted while `busy` is high returns a status byte in which bit 7 (data poll) is 0 and bit 5 (timeout) is 0.
- R5: Bit 6 of the status byte inverts on every status read accepted. After completion, two consecutive reads show the same bit 6.
- R6: If `force_fail` is held and MAX_PULSES erase pulses have been applied without a passing verify, `busy` falls. Status reads then return bit 5 = 1 and bit 7 = 0.
- R7: The failed state lasts until a `reset_cmd` pulse, which returns the block to array reads. A `reset_cmd` while idle changes no array contents.
- R8: Host writes change a location only while the block is idle. Writes made while busy or failed are dropped.
- R9: `rq_ready` is low while a response is held un-taken. A held response keeps its `rs_data` stable until `rs_ready` is high.
- R10: `busy` never stays high for more than 2*DEPTH + MAX_PULSES*(PULSE_CYC+DEPTH) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle erase start pulse from the command decoder |
| reset_cmd | input | 1 | One-cycle reset command; clears the failed state |
| force_fail | input | 1 | Test input; keeps cells from reaching the erased value |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request ready |
| rq_addr | input | ADDR_W | Read request address |
| rs_valid | output | 1 | Read response valid |
| rs_ready | input | 1 | Read response ready |
| rs_data | output | 8 | Array data, or the status byte while busy or failed |
| busy | output | 1 | High while the erase sequence runs |

## Verification
The checker watches several behaviours on every cycle. It checks that `busy` rises after a start pulse taken while idle. It checks that status responses taken during busy carry a clear poll bit and a clear timeout bit, and that responses taken in the failed state carry the timeout flag. It checks that the failed state is held without a reset command, that held responses stay stable, and that the busy period stays within its bound. Some outcomes only the bench scenarios can show. These are the pre-programmed zeros left after a timeout, the all-0xFF array after a successful erase, dropped writes, ignored start pulses, and the toggle bit going quiet on completion.

// File: rtl/erase_pkg.sv
package erase_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_PREPROG, PH_PREVER, PH_PULSE, PH_EVER, PH_FAIL
  } phase_t;

  localparam logic [7:0] CELL_ZERO   = 8'h00;
  localparam logic [7:0] CELL_ERASED = 8'hFF;

  function automatic logic [7:0] status_byte(input logic tog, input logic tmo);
    return {1'b0, tog, tmo, 5'b00000};
  endfunction
endpackage

// File: rtl/erase_array.sv
module erase_array #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              bulk_set,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [7:0]        rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [7:0]        rdata_b
);
  logic [7:0] cell_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= erase_pkg::CELL_ERASED;
      else if (bulk_set)                           q <= erase_pkg::CELL_ERASED;
      else if (we && waddr == ADDR_W'(g))          q <= wdata;
    end
    assign cell_w[g] = q;
  end

  assign rdata_a = cell_w[raddr_a];
  assign rdata_b = cell_w[raddr_b];
endmodule

// File: rtl/erase_fsm.sv
module erase_fsm
  import erase_pkg::*;
#(
  parameter int DEPTH           = 8,
  parameter int PULSE_CYC       = 4,
  parameter int PULSES_TO_ERASE = 2,
  parameter int MAX_PULSES      = 4,
  parameter int ADDR_W          = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              reset_cmd,
  input  logic              force_fail,
  input  logic [7:0]        cell_rd,
  output logic [ADDR_W-1:0] cell_addr,
  output logic              cell_we,
  output logic              bulk_set,
  output logic              busy,
  output logic              fail_st
);
  localparam int CYC_W = $clog2(PULSE_CYC + 1);
  localparam int NP_W  = $clog2(MAX_PULSES + 1);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  phase_t            phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic [NP_W-1:0]   np_q, np_d;

  always_comb begin
    phase_d  = phase_q;
    addr_d   = addr_q;
    cyc_d    = cyc_q;
    np_d     = np_q;
    cell_we  = 1'b0;
    bulk_set = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_PREPROG;
        addr_d  = '0;
        np_d    = '0;
      end
      PH_PREPROG: begin
        cell_we = 1'b1;
        if (addr_q == LAST) begin
          phase_d = PH_PREVER;
          addr_d  = '0;
        end else addr_d = addr_q + 1'b1;
      end
      PH_PREVER: begin
        if (cell_rd != CELL_ZERO) begin
          phase_d = PH_PREPROG;
          addr_d  = '0;
        end else if (addr_q == LAST) begin
          phase_d = PH_PULSE;
          cyc_d   = '0;
        end else addr_d = addr_q + 1'b1;
      end
      PH_PULSE: begin
        if (int'(cyc_q) == PULSE_CYC - 1) begin
          np_d     = np_q + 1'b1;
          bulk_set = (int'(np_q) + 1 >= PULSES_TO_ERASE) && !force_fail;
          phase_d  = PH_EVER;
          addr_d   = '0;
        end else cyc_d = cyc_q + 1'b1;
      end
      PH_EVER: begin
        if (cell_rd != CELL_ERASED) begin
          if (int'(np_q) >= MAX_PULSES) phase_d = PH_FAIL;
          else begin
            phase_d = PH_PULSE;
            cyc_d   = '0;
          end
        end else if (addr_q == LAST) phase_d = PH_IDLE;
        else addr_d = addr_q + 1'b1;
      end
      PH_FAIL: if (reset_cmd) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      cyc_q   <= '0;
      np_q    <= '0;
    end else begin
      phase_q <= phase_d;
      addr_q  <= addr_d;
      cyc_q   <= cyc_d;
      np_q    <= np_d;
    end
  end

  assign cell_addr = addr_q;
  assign fail_st   = (phase_q == PH_FAIL);
  assign busy      = (phase_q != PH_IDLE) && (phase_q != PH_FAIL);
endmodule

// File: rtl/erase_status.sv
module erase_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       fail_st,
  output logic [7:0] status
);
  logic tog_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tog_q <= 1'b0;
    else if (take) tog_q <= ~tog_q;
  end
  assign status = erase_pkg::status_byte(tog_q, fail_st);
endmodule

// File: rtl/erase_engine.sv
module erase_engine #(
  parameter int DEPTH           = 8,
  parameter int PULSE_CYC       = 4,
  parameter int PULSES_TO_ERASE = 2,
  parameter int MAX_PULSES      = 4,
  parameter int ADDR_W          = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              reset_cmd,
  input  logic              force_fail,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rq_valid,
  output logic              rq_ready,
  input  logic [ADDR_W-1:0] rq_addr,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic [7:0]        rs_data,
  output logic              busy
);
  logic [ADDR_W-1:0] seq_addr, arr_waddr;
  logic              seq_we, bulk_set, fail_st, locked, take, arr_we;
  logic [7:0]        host_rd, seq_rd, arr_wdata, status;

  assign locked    = busy || fail_st;
  assign arr_we    = busy ? seq_we : (wr_en && !fail_st);
  assign arr_waddr = busy ? seq_addr : wr_addr;
  assign arr_wdata = busy ? erase_pkg::CELL_ZERO : wr_data;

  erase_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .bulk_set(bulk_set), .raddr_a(rq_addr), .rdata_a(host_rd),
    .raddr_b(seq_addr), .rdata_b(seq_rd)
  );

  erase_fsm #(
    .DEPTH(DEPTH), .PULSE_CYC(PULSE_CYC), .PULSES_TO_ERASE(PULSES_TO_ERASE),
    .MAX_PULSES(MAX_PULSES), .ADDR_W(ADDR_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .reset_cmd(reset_cmd),
    .force_fail(force_fail), .cell_rd(seq_rd), .cell_addr(seq_addr),
    .cell_we(seq_we), .bulk_set(bulk_set), .busy(busy), .fail_st(fail_st)
  );

  erase_status u_status (
    .clk(clk), .rst_n(rst_n), .take(take && locked), .fail_st(fail_st), .status(status)
  );

  assign rq_ready = !rs_valid || rs_ready;
  assign take     = rq_valid && rq_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_data  <= '0;
    end else if (take) begin
      rs_valid <= 1'b1;
      rs_data  <= locked ? status : host_rd;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/erase_engine_chk.sv
module erase_engine_chk #(
  parameter int DEPTH      = 8,
  parameter int PULSE_CYC  = 4,
  parameter int MAX_PULSES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       reset_cmd,
  input logic       rq_valid,
  input logic       rq_ready,
  input logic       rs_valid,
  input logic       rs_ready,
  input logic [7:0] rs_data,
  input logic       busy,
  input logic       fail_st
);
  localparam int LIMIT = 2 * DEPTH + MAX_PULSES * (PULSE_CYC + DEPTH);

  a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !fail_st) |=> busy);

  a_r4_busy_status: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_ready && busy) |=> (!rs_data[7] && !rs_data[5]));

  a_r6_fail_status: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_ready && fail_st) |=> (rs_data[5] && !rs_data[7]));

  a_r6_fail_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fail_st |-> !busy);

  a_r7_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_st && !reset_cmd) |=> fail_st);

  a_r9_hold_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_data)));

  int busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= 0;
    else begin
      busy_cnt <= busy ? busy_cnt + 1 : 0;
      a_r10_busy_bound: assert (busy_cnt <= LIMIT)
        else $error("busy held %0d cycles", busy_cnt);
    end
  end
endmodule

bind erase_engine erase_engine_chk #(
  .DEPTH(DEPTH), .PULSE_CYC(PULSE_CYC), .MAX_PULSES(MAX_PULSES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .reset_cmd(reset_cmd),
  .rq_valid(rq_valid), .rq_ready(rq_ready), .rs_valid(rs_valid),
  .rs_ready(rs_ready), .rs_data(rs_data), .busy(busy), .fail_st(fail_st)
);

// File: tb/erase_engine_test.sv
module erase_engine_test;
  localparam int DEPTH = 8, PULSE_CYC = 4, PULSES_TO_ERASE = 2, MAX_PULSES = 4;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int BUSY_LIMIT = 2 * DEPTH + MAX_PULSES * (PULSE_CYC + DEPTH);
  localparam logic [10:0] WTAB [8] = '{
    {3'd0, 8'h12}, {3'd1, 8'hA0}, {3'd2, 8'h5A}, {3'd3, 8'h01},
    {3'd4, 8'hFE}, {3'd5, 8'h80}, {3'd6, 8'h33}, {3'd7, 8'hC7}};

  logic clk = 0, rst_n = 0, start = 0, reset_cmd = 0, force_fail = 0;
  logic wr_en = 0, rq_valid = 0, rs_ready = 1;
  logic [ADDR_W-1:0] wr_addr = '0, rq_addr = '0;
  logic [7:0] wr_data = '0;
  logic rq_ready, rs_valid, busy;
  logic [7:0] rs_data;
  int checks = 0, errors = 0, busy_cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) if (busy) busy_cycles <= busy_cycles + 1;

  erase_engine #(.DEPTH(DEPTH), .PULSE_CYC(PULSE_CYC), .PULSES_TO_ERASE(PULSES_TO_ERASE),
    .MAX_PULSES(MAX_PULSES)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .reset_cmd(reset_cmd), .force_fail(force_fail),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rq_valid(rq_valid),
    .rq_ready(rq_ready), .rq_addr(rq_addr), .rs_valid(rs_valid), .rs_ready(rs_ready),
    .rs_data(rs_data), .busy(busy));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic read(input int a, output logic [7:0] d);
    @(negedge clk); rq_valid = 1; rq_addr = ADDR_W'(a);
    @(negedge clk); rq_valid = 0; d = rs_data;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); reset_cmd = 1;
    @(negedge clk); reset_cmd = 0;
  endtask

  initial begin
    logic [7:0] d, p, q;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0, "R1 reset busy", busy, 0);
    check(rq_ready == 1 && rs_valid == 0, "R9 reset handshake", {rq_ready, rs_valid}, 2);

    // vector table: idle writes land (R8)
    foreach (WTAB[i]) write(int'(WTAB[i][10:8]), WTAB[i][7:0]);
    foreach (WTAB[i]) begin
      read(int'(WTAB[i][10:8]), d);
      check(d == WTAB[i][7:0], "R8 idle write", d, WTAB[i][7:0]);
    end

    // successful erase
    busy_cycles = 0;
    pulse_start();
    check(busy == 1, "R1 busy after start", busy, 1);
    read(0, p);
    check(p[7] == 0 && p[5] == 0, "R4 busy status", p, 8'h00);
    read(0, q);
    check(q[6] != p[6], "R5 toggle while busy", q[6], ~p[6]);
    write(2, 8'h55);      // dropped, busy (R8)
    pulse_start();        // ignored, busy (R1)
    p = q;
    for (int k = 0; k < 400; k++) begin
      read(0, q);
      if (busy == 0 && q[6] == p[6]) break;
      p = q;
    end
    check(busy == 0, "R3 busy falls", busy, 0);
    check(q[6] == p[6], "R5 toggle stopped", q[6], p[6]);
    check(busy_cycles <= BUSY_LIMIT, "R10 busy bound", busy_cycles, BUSY_LIMIT);
    for (int a = 0; a < DEPTH; a++) begin
      read(a, d);
      check(d == 8'hFF, "R3 erased value (R8 busy write dropped)", d, 8'hFF);
    end

    // reset command while idle changes nothing (R7)
    write(1, 8'h3C);
    pulse_reset();
    read(1, d);
    check(d == 8'h3C, "R7 idle reset no effect", d, 8'h3C);

    // timeout path
    write(4, 8'h9D);
    force_fail = 1;
    busy_cycles = 0;
    pulse_start();
    q = 8'h00;
    for (int k = 0; k < 400; k++) begin
      read(0, q);
      if (q[5]) break;
    end
    check(busy == 0, "R6 busy falls on timeout", busy, 0);
    check(q[5] == 1 && q[7] == 0, "R6 timeout status", q, 8'h20);
    check(busy_cycles <= BUSY_LIMIT, "R10 busy bound timeout", busy_cycles, BUSY_LIMIT);
    read(0, p);
    check(p[6] != q[6], "R5 toggle in failed state", p[6], ~q[6]);
    write(3, 8'h77);      // dropped, failed (R8)
    pulse_start();        // ignored, failed (R1)
    check(busy == 0, "R1 start ignored when failed", busy, 0);
    repeat (10) @(negedge clk);
    read(5, d);
    check(d[5] == 1, "R7 failed state held", d, 8'h20);
    force_fail = 0;
    pulse_reset();
    for (int a = 0; a < DEPTH; a++) begin
      read(a, d);
      check(d == 8'h00, "R2 preprogram zeros (R7 read mode, R8 fail write dropped)", d, 8'h00);
    end

    // back-pressure (R9)
    @(negedge clk); rs_ready = 0; rq_valid = 1; rq_addr = 0;
    @(negedge clk);
    check(rs_valid == 1 && rq_ready == 0, "R9 held response blocks", {rs_valid, rq_ready}, 2);
    d = rs_data;
    rq_addr = 5;
    wr_en = 1; wr_addr = 0; wr_data = 8'hA5;
    @(negedge clk); wr_en = 0;
    check(rs_data == d && d == 8'h00, "R9 response stable", rs_data, 8'h00);
    rq_valid = 0; rs_ready = 1;
    @(negedge clk);
    check(rs_valid == 0, "R9 response drained", rs_valid, 0);
    read(0, d);
    check(d == 8'hA5, "R8 idle write during hold", d, 8'hA5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule